// File: doc/BRIEF.md
# Rename-Stage Early Execution Unit

This unit sits beside register rename and looks at one rename group of up to eight micro-ops per cycle. It executes the simple single-cycle integer operations whose operands can all be had at rename time, so that those micro-ops never need an issue slot in the out-of-order engine. An operand is available at rename when it is an immediate, when an older micro-op of the same group has either been executed here or carries a value prediction, or when the producing micro-op was executed here or predicted in the cycle just before.

Forwarding inside a group runs strictly from older slots to younger ones, so a chain of dependent additions or logic operations resolves in one cycle. Values produced in one cycle are kept for exactly one following cycle in a small store indexed by physical destination tag. A flush drops the group of that cycle and empties the store. Moves of an immediate into a register are always executed here. Results are not checked again later: every speculative chain begins at an older value-predicted micro-op that is validated before commit.

Top module: `early_exec_unit`

## Requirements
- R1: While reset is high, and in the first cycle after it, every early-executed flag and every result is 0, and no value recorded before or during reset can satisfy a previous-cycle operand.
- R2: The operation codes are 0 add, 1 subtract (A minus B), 2 and, 3 or, 4 xor and 5 move of A; all act on 64-bit data and wrap modulo 2^64.
- R3: A valid slot with code 6 (immediate move) is always early-executed with result equal to its A value, whatever its eligible flag and operand kinds.
- R4: An invalid slot, a slot with code 7, or a slot with code 0 to 5 whose eligible flag is 0 is never early-executed; a slot that is not early-executed shows result 0.
- R5: Operand kind 0 is an immediate and is always ready with the slot's own operand value; kind 3 is a register read by the out-of-order engine and is never ready.
- R6: Operand kind 1 names a slot index in the same group; it is ready only if that index is below the consumer's own index and the named slot is valid and either early-executed or predicted. Its value is the executed result, or otherwise the predicted value.
- R7: Operand kind 2 names a physical tag; it is ready only if some valid slot of the immediately preceding cycle with that destination tag was early-executed or predicted, and its value is that of the highest-indexed such slot (executed result before prediction).
- R8: When flush is high, the group of that cycle is discarded (all flags and results 0 in the next cycle, nothing recorded) and no previous-cycle operand is ready in the following cycle.
- R9: Flags and results appear one clock edge after the group is presented and hold until the next edge.
- R10: A move (code 5) needs only operand A; the kind and value of operand B have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Discard this group and empty the previous-cycle store |
| slot_valid_i | input | NSLOT | Slot holds a micro-op |
| alu_ok_i | input | NSLOT | Slot is a single-cycle ALU micro-op |
| op_i | input | NSLOT*3 | Operation code per slot |
| a_kind_i | input | NSLOT*2 | Source kind of operand A |
| a_sel_i | input | NSLOT*TW | Slot index or physical tag of operand A |
| a_val_i | input | NSLOT*DW | Immediate value of operand A |
| b_kind_i | input | NSLOT*2 | Source kind of operand B |
| b_sel_i | input | NSLOT*TW | Slot index or physical tag of operand B |
| b_val_i | input | NSLOT*DW | Immediate value of operand B |
| pred_valid_i | input | NSLOT | Slot carries a confident value prediction |
| pred_val_i | input | NSLOT*DW | Predicted result |
| dst_tag_i | input | NSLOT*TW | Physical destination tag |
| ee_o | output | NSLOT | Slot was early-executed |
| res_o | output | NSLOT*DW | Early-executed result |

## Verification
Every flag and result is due exactly one rising edge after its group is driven, so the bench drives each group on a falling edge, computes the expected outcome at once, and compares it at the next falling edge, half a period after the registers have loaded. Previous-cycle operands depend on the group one cycle older again, so the reference model keeps the producer map of the last group and swaps it in at each falling edge before working out the new group. A directed check samples just before the capturing edge to confirm that nothing appears early.

// File: rtl/eeu_pkg.sv
package eeu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_MOV  = 3'd5,
    OP_MOVI = 3'd6,
    OP_RSVD = 3'd7
  } eeu_op_e;

  typedef enum logic [1:0] {
    SRC_IMM  = 2'd0,
    SRC_GRP  = 2'd1,
    SRC_PREV = 2'd2,
    SRC_REG  = 2'd3
  } eeu_src_e;

  function automatic logic op_is_simple(input logic [2:0] op);
    return op <= OP_MOV;
  endfunction

  function automatic logic op_needs_b(input logic [2:0] op);
    return op <= OP_XOR;
  endfunction

endpackage

// File: rtl/eeu_prev_table.sv
module eeu_prev_table #(
  parameter int NSLOT = 8,
  parameter int DW    = 64,
  parameter int TW    = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush_i,
  input  logic [NSLOT-1:0]           wr_en_i,
  input  logic [NSLOT-1:0][TW-1:0]   wr_tag_i,
  input  logic [NSLOT-1:0][DW-1:0]   wr_val_i,
  input  logic [NSLOT-1:0][TW-1:0]   rd_tag_a_i,
  input  logic [NSLOT-1:0][TW-1:0]   rd_tag_b_i,
  output logic [NSLOT-1:0]           rd_hit_a_o,
  output logic [NSLOT-1:0][DW-1:0]   rd_val_a_o,
  output logic [NSLOT-1:0]           rd_hit_b_o,
  output logic [NSLOT-1:0][DW-1:0]   rd_val_b_o
);

  localparam int NENT = 1 << TW;

  logic [DW-1:0]   mem [NENT];
  logic [NENT-1:0] live_q;
  logic [NENT-1:0] live_n;

  // later slots are younger; the last write in the loop wins
  always_ff @(posedge clk) begin
    for (int i = 0; i < NSLOT; i++) begin
      if (wr_en_i[i] && !flush_i) begin
        mem[wr_tag_i[i]] <= wr_val_i[i];
      end
    end
  end

  always_comb begin
    live_n = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (wr_en_i[i]) begin
        live_n[wr_tag_i[i]] = 1'b1;
      end
    end
    if (flush_i) begin
      live_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= '0;
    end else begin
      live_q <= live_n;
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_rd
    assign rd_hit_a_o[g] = live_q[rd_tag_a_i[g]];
    assign rd_val_a_o[g] = mem[rd_tag_a_i[g]];
    assign rd_hit_b_o[g] = live_q[rd_tag_b_i[g]];
    assign rd_val_b_o[g] = mem[rd_tag_b_i[g]];

    // R7: an entry written by a surviving slot is live in the next cycle
    a_r7_written_live: assert property (@(posedge clk) disable iff (rst)
      (wr_en_i[g] && !flush_i) |=> live_q[$past(wr_tag_i[g])]);
  end

  // R8: a flush leaves no live entry behind
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (live_q == '0));

  // R7: entries survive one cycle only
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i == '0) |=> (live_q == '0));

endmodule

// File: rtl/eeu_group_core.sv
module eeu_group_core
  import eeu_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int DW    = 64,
  parameter int TW    = 6
) (
  input  logic                       flush_i,
  input  logic [NSLOT-1:0]           slot_valid_i,
  input  logic [NSLOT-1:0]           alu_ok_i,
  input  logic [NSLOT-1:0][2:0]      op_i,
  input  logic [NSLOT-1:0][1:0]      a_kind_i,
  input  logic [NSLOT-1:0][TW-1:0]   a_sel_i,
  input  logic [NSLOT-1:0][DW-1:0]   a_val_i,
  input  logic [NSLOT-1:0][1:0]      b_kind_i,
  input  logic [NSLOT-1:0][TW-1:0]   b_sel_i,
  input  logic [NSLOT-1:0][DW-1:0]   b_val_i,
  input  logic [NSLOT-1:0]           pred_valid_i,
  input  logic [NSLOT-1:0][DW-1:0]   pred_val_i,
  input  logic [NSLOT-1:0]           a_hit_i,
  input  logic [NSLOT-1:0][DW-1:0]   a_prev_i,
  input  logic [NSLOT-1:0]           b_hit_i,
  input  logic [NSLOT-1:0][DW-1:0]   b_prev_i,
  output logic [NSLOT-1:0]           exec_o,
  output logic [NSLOT-1:0][DW-1:0]   result_o,
  output logic [NSLOT-1:0]           wr_en_o,
  output logic [NSLOT-1:0][DW-1:0]   wr_val_o
);

  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  function automatic logic [DW-1:0] alu_f(input logic [2:0] op,
                                          input logic [DW-1:0] a,
                                          input logic [DW-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      default: return a;
    endcase
  endfunction

  // returns {ready, value}
  function automatic logic [DW:0] pick_f(input logic [1:0]            kind,
                                         input logic [TW-1:0]         sel,
                                         input logic [DW-1:0]         imm,
                                         input logic                  hit,
                                         input logic [DW-1:0]         pval,
                                         input int                    idx,
                                         input logic [NSLOT-1:0]         avail,
                                         input logic [NSLOT-1:0][DW-1:0] fwd);
    logic [SW-1:0] j;
    j = sel[SW-1:0];
    case (kind)
      SRC_IMM:  return {1'b1, imm};
      SRC_GRP:  begin
        if (int'(sel) < idx) return {avail[j], fwd[j]};
        else                 return {1'b0, {DW{1'b0}}};
      end
      SRC_PREV: return {hit, pval};
      default:  return {1'b0, {DW{1'b0}}};
    endcase
  endfunction

  logic [NSLOT-1:0]         avail_c;
  logic [NSLOT-1:0][DW-1:0] fwd_c;
  logic [NSLOT-1:0]         exec_c;
  logic [NSLOT-1:0][DW-1:0] res_c;

  always_comb begin
    logic [DW:0] opa;
    logic [DW:0] opb;
    logic        live;
    avail_c = '0;
    fwd_c   = '0;
    exec_c  = '0;
    res_c   = '0;
    for (int i = 0; i < NSLOT; i++) begin
      opa  = pick_f(a_kind_i[i], a_sel_i[i], a_val_i[i], a_hit_i[i], a_prev_i[i],
                    i, avail_c, fwd_c);
      opb  = pick_f(b_kind_i[i], b_sel_i[i], b_val_i[i], b_hit_i[i], b_prev_i[i],
                    i, avail_c, fwd_c);
      live = slot_valid_i[i] && !flush_i;
      if (live && op_i[i] == OP_MOVI) begin
        exec_c[i] = 1'b1;
        res_c[i]  = a_val_i[i];
      end else if (live && alu_ok_i[i] && op_is_simple(op_i[i]) && opa[DW] &&
                   (opb[DW] || !op_needs_b(op_i[i]))) begin
        exec_c[i] = 1'b1;
        res_c[i]  = alu_f(op_i[i], opa[DW-1:0], opb[DW-1:0]);
      end
      avail_c[i] = exec_c[i] || (live && pred_valid_i[i]);
      fwd_c[i]   = exec_c[i] ? res_c[i] : pred_val_i[i];
    end
  end

  assign exec_o   = exec_c;
  assign result_o = res_c;
  assign wr_en_o  = avail_c;
  assign wr_val_o = fwd_c;

endmodule

// File: rtl/early_exec_unit.sv
module early_exec_unit
  import eeu_pkg::*;
#(
  parameter int NSLOT = 8,
  parameter int DW    = 64,
  parameter int TW    = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush_i,
  input  logic [NSLOT-1:0]           slot_valid_i,
  input  logic [NSLOT-1:0]           alu_ok_i,
  input  logic [NSLOT-1:0][2:0]      op_i,
  input  logic [NSLOT-1:0][1:0]      a_kind_i,
  input  logic [NSLOT-1:0][TW-1:0]   a_sel_i,
  input  logic [NSLOT-1:0][DW-1:0]   a_val_i,
  input  logic [NSLOT-1:0][1:0]      b_kind_i,
  input  logic [NSLOT-1:0][TW-1:0]   b_sel_i,
  input  logic [NSLOT-1:0][DW-1:0]   b_val_i,
  input  logic [NSLOT-1:0]           pred_valid_i,
  input  logic [NSLOT-1:0][DW-1:0]   pred_val_i,
  input  logic [NSLOT-1:0][TW-1:0]   dst_tag_i,
  output logic [NSLOT-1:0]           ee_o,
  output logic [NSLOT-1:0][DW-1:0]   res_o
);

  logic [NSLOT-1:0]         a_hit, b_hit;
  logic [NSLOT-1:0][DW-1:0] a_prev, b_prev;
  logic [NSLOT-1:0]         exec_c, wr_en;
  logic [NSLOT-1:0][DW-1:0] res_c, wr_val;

  eeu_prev_table #(.NSLOT(NSLOT), .DW(DW), .TW(TW)) u_table (
    .clk        (clk),
    .rst        (rst),
    .flush_i    (flush_i),
    .wr_en_i    (wr_en),
    .wr_tag_i   (dst_tag_i),
    .wr_val_i   (wr_val),
    .rd_tag_a_i (a_sel_i),
    .rd_tag_b_i (b_sel_i),
    .rd_hit_a_o (a_hit),
    .rd_val_a_o (a_prev),
    .rd_hit_b_o (b_hit),
    .rd_val_b_o (b_prev)
  );

  eeu_group_core #(.NSLOT(NSLOT), .DW(DW), .TW(TW)) u_core (
    .flush_i      (flush_i),
    .slot_valid_i (slot_valid_i),
    .alu_ok_i     (alu_ok_i),
    .op_i         (op_i),
    .a_kind_i     (a_kind_i),
    .a_sel_i      (a_sel_i),
    .a_val_i      (a_val_i),
    .b_kind_i     (b_kind_i),
    .b_sel_i      (b_sel_i),
    .b_val_i      (b_val_i),
    .pred_valid_i (pred_valid_i),
    .pred_val_i   (pred_val_i),
    .a_hit_i      (a_hit),
    .a_prev_i     (a_prev),
    .b_hit_i      (b_hit),
    .b_prev_i     (b_prev),
    .exec_o       (exec_c),
    .result_o     (res_c),
    .wr_en_o      (wr_en),
    .wr_val_o     (wr_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ee_o  <= '0;
      res_o <= '0;
    end else begin
      ee_o  <= exec_c;
      res_o <= res_c;
    end
  end

  // R8: a flushed group never shows up
  a_r8_flush_drops: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (ee_o == '0));

  for (genvar g = 0; g < NSLOT; g++) begin : g_chk
    // R4: ineligible micro-ops stay with the out-of-order engine
    a_r4_ineligible: assert property (@(posedge clk) disable iff (rst)
      (slot_valid_i[g] && !alu_ok_i[g] && op_i[g] != OP_MOVI) |=> !ee_o[g]);

    // R4: a slot not executed shows a zero result
    a_r4_zero_result: assert property (@(posedge clk) disable iff (rst)
      !ee_o[g] |-> (res_o[g] == '0));

    // R3: immediate moves always execute with their immediate
    a_r3_movi: assert property (@(posedge clk) disable iff (rst)
      (slot_valid_i[g] && op_i[g] == OP_MOVI && !flush_i)
      |=> (ee_o[g] && res_o[g] == $past(a_val_i[g])));
  end

  // R6: the oldest slot has no older slot to forward from
  a_r6_slot0_no_group: assert property (@(posedge clk) disable iff (rst)
    (op_i[0] != OP_MOVI && (a_kind_i[0] == SRC_GRP ||
     (b_kind_i[0] == SRC_GRP && op_i[0] != OP_MOV))) |=> !ee_o[0]);

endmodule

// File: tb/early_exec_unit_tb.sv
module early_exec_unit_tb;

  localparam int W  = 8;
  localparam int DW = 64;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush_i;
  logic [W-1:0]           slot_valid_i, alu_ok_i, pred_valid_i;
  logic [W-1:0][2:0]      op_i;
  logic [W-1:0][1:0]      a_kind_i, b_kind_i;
  logic [W-1:0][TW-1:0]   a_sel_i, b_sel_i, dst_tag_i;
  logic [W-1:0][DW-1:0]   a_val_i, b_val_i, pred_val_i;
  logic [W-1:0]           ee_o;
  logic [W-1:0][DW-1:0]   res_o;

  always #5 clk = ~clk;

  early_exec_unit #(.NSLOT(W), .DW(DW), .TW(TW)) u_dut (
    .clk(clk), .rst(rst), .flush_i(flush_i),
    .slot_valid_i(slot_valid_i), .alu_ok_i(alu_ok_i), .op_i(op_i),
    .a_kind_i(a_kind_i), .a_sel_i(a_sel_i), .a_val_i(a_val_i),
    .b_kind_i(b_kind_i), .b_sel_i(b_sel_i), .b_val_i(b_val_i),
    .pred_valid_i(pred_valid_i), .pred_val_i(pred_val_i),
    .dst_tag_i(dst_tag_i), .ee_o(ee_o), .res_o(res_o)
  );

  int errs = 0;
  int checks = 0;

  // reference model state
  logic [DW-1:0] prev_map [int];
  logic [DW-1:0] next_map [int];
  bit            m_av [W];
  logic [DW-1:0] m_fw [W];
  bit            exp_ee [W];
  logic [DW-1:0] exp_res [W];
  string         exp_tag [W];
  bit            have_pend = 0;

  function automatic logic [DW-1:0] ref_alu(int op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      default: return a;
    endcase
  endfunction

  function automatic bit src_ready(int kind, int sel, int idx, logic [DW-1:0] imm,
                                   output logic [DW-1:0] v);
    v = '0;
    if (kind == 0) begin v = imm; return 1; end
    if (kind == 1) begin
      if (sel < idx && m_av[sel]) begin v = m_fw[sel]; return 1; end
      return 0;
    end
    if (kind == 2) begin
      if (prev_map.exists(sel)) begin v = prev_map[sel]; return 1; end
      return 0;
    end
    return 0;
  endfunction

  task automatic model_eval();
    next_map.delete();
    for (int i = 0; i < W; i++) begin
      bit live, ra, rb, e;
      logic [DW-1:0] va, vb, r;
      int op;
      op = int'(op_i[i]);
      live = slot_valid_i[i] && !flush_i;
      ra = src_ready(int'(a_kind_i[i]), int'(a_sel_i[i]), i, a_val_i[i], va);
      rb = src_ready(int'(b_kind_i[i]), int'(b_sel_i[i]), i, b_val_i[i], vb);
      e = 0; r = '0;
      if (live && op == 6) begin e = 1; r = a_val_i[i]; end
      else if (live && alu_ok_i[i] && op <= 5 && ra && (rb || op == 5)) begin
        e = 1; r = ref_alu(op, va, vb);
      end
      m_av[i] = e || (live && pred_valid_i[i]);
      m_fw[i] = e ? r : pred_val_i[i];
      exp_ee[i] = e; exp_res[i] = r;
      if (flush_i) exp_tag[i] = "R8";
      else if (!slot_valid_i[i] || op == 7 || (op <= 5 && !alu_ok_i[i])) exp_tag[i] = "R4";
      else if (op == 6) exp_tag[i] = "R3";
      else if (op == 5 && b_kind_i[i] != 2'd0) exp_tag[i] = "R10";
      else if (a_kind_i[i] == 2'd1 || (op != 5 && b_kind_i[i] == 2'd1)) exp_tag[i] = "R6";
      else if (a_kind_i[i] == 2'd2 || (op != 5 && b_kind_i[i] == 2'd2)) exp_tag[i] = "R7";
      else if (a_kind_i[i] == 2'd3 || (op != 5 && b_kind_i[i] == 2'd3)) exp_tag[i] = "R5";
      else exp_tag[i] = "R2";
    end
    for (int i = 0; i < W; i++) begin
      if (m_av[i]) next_map[int'(dst_tag_i[i])] = m_fw[i];
    end
    have_pend = 1;
  endtask

  task automatic compare_pending();
    if (!have_pend) return;
    for (int i = 0; i < W; i++) begin
      checks++;
      if (ee_o[i] !== exp_ee[i] || res_o[i] !== exp_res[i]) begin
        errs++;
        $display("FAIL %s slot %0d: ee=%0b res=%h expected ee=%0b res=%h",
                 exp_tag[i], i, ee_o[i], res_o[i], exp_ee[i], exp_res[i]);
      end
    end
    prev_map = next_map;
  endtask

  task automatic clear_inputs();
    flush_i = 0; slot_valid_i = '0; alu_ok_i = '0; pred_valid_i = '0;
    op_i = '0; a_kind_i = '0; b_kind_i = '0; a_sel_i = '0; b_sel_i = '0;
    dst_tag_i = '0; a_val_i = '0; b_val_i = '0; pred_val_i = '0;
  endtask

  function automatic logic [TW-1:0] rnd_tag();
    if ($urandom_range(3) == 0) return TW'(56 + $urandom_range(7));
    return TW'($urandom_range(7));
  endfunction

  task automatic random_inputs();
    flush_i = ($urandom_range(19) == 0);
    for (int i = 0; i < W; i++) begin
      slot_valid_i[i] = ($urandom_range(7) != 0);
      alu_ok_i[i]     = ($urandom_range(3) != 0);
      op_i[i]         = 3'($urandom_range(7));
      a_kind_i[i]     = 2'($urandom_range(3));
      b_kind_i[i]     = 2'($urandom_range(3));
      a_sel_i[i]      = rnd_tag();
      b_sel_i[i]      = rnd_tag();
      dst_tag_i[i]    = rnd_tag();
      a_val_i[i]      = {$urandom, $urandom};
      b_val_i[i]      = ($urandom_range(3) == 0) ? {DW{1'b1}} : {$urandom, $urandom};
      pred_valid_i[i] = ($urandom_range(1) == 0);
      pred_val_i[i]   = {$urandom, $urandom};
    end
  endtask

  task automatic check_bit(string tag, bit cond, string what);
    checks++;
    if (!cond) begin
      errs++;
      $display("FAIL %s: %s ee=%b expected 0", tag, what, ee_o);
    end
  endtask

  initial begin
    clear_inputs();
    // R1: outputs stay zero through reset
    repeat (3) begin
      @(negedge clk);
      check_bit("R1", ee_o == '0 && res_o == '0, "reset outputs");
    end
    // first group after reset: chain and a stale-tag probe
    rst = 0;
    slot_valid_i = 8'h0F; alu_ok_i = 8'h0F;
    op_i[0] = 3'd6; a_val_i[0] = 64'h0000_0000_0000_0010; dst_tag_i[0] = 6'd3;
    op_i[1] = 3'd0; a_kind_i[1] = 2'd1; a_sel_i[1] = 6'd0; b_val_i[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    op_i[2] = 3'd1; a_kind_i[2] = 2'd1; a_sel_i[2] = 6'd1; b_kind_i[2] = 2'd0; b_val_i[2] = 64'd20;
    op_i[3] = 3'd2; a_kind_i[3] = 2'd2; a_sel_i[3] = 6'd3; b_val_i[3] = '1;
    model_eval();
    #3;
    // R9: nothing appears before the capturing edge
    check_bit("R9", ee_o == '0, "before edge");
    @(negedge clk);
    compare_pending();
    // second group reads tag 3 from the previous cycle (R7)
    clear_inputs();
    slot_valid_i = 8'h03; alu_ok_i = 8'h03;
    op_i[0] = 3'd4; a_kind_i[0] = 2'd2; a_sel_i[0] = 6'd3; b_val_i[0] = 64'h5;
    op_i[1] = 3'd5; a_kind_i[1] = 2'd0; a_val_i[1] = 64'h77; b_kind_i[1] = 2'd3;
    model_eval();
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      compare_pending();
      random_inputs();
      model_eval();
    end
    @(negedge clk);
    compare_pending();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not end, actual running expected done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule